// File: doc/BRIEF.md
# PLL Clock Configuration Lock Controller

This block holds the 3-bit clock configuration of a chip and tracks whether the PLL is locked. A configuration value either picks a PLL multiplication factor or picks one of two modes that do not use the PLL: direct drive (`001`) or prescaler (`011`). When software writes a PLL configuration that differs from the one in effect, the block enters an unlocked phase. In that phase the lock flag is cleared, a lock counter restarts, and a PLL interrupt request is raised. The counter models the analog lock detector. It counts pulses on a reference-pulse input while the configuration stays stable. When the count reaches a programmable limit, the lock flag is set.

An oscillator-missing input comes from an oscillator watchdog. While it is high, the PLL base frequency takes the place of the oscillator clock. In direct drive the base frequency is used unchanged, and in prescaler mode it is halved. The block also holds the lock flag cleared for as long as the input stays high.

The PLL request and a second group of requests share one interrupt node. Each source has a request bit and an enable bit in a subnode register that software can write. The node output is the OR, over all sources, of request AND enable. All pins are plain control and status signals, with no handshake.

Top module: `pll_cfg_lock_ctrl`

## Requirements
- R1: After reset, `cfg_o` equals `RESET_CFG` (default `001`), and `lock_o`, `pll_req_o`, `node_irq_o` and `sub_q_o` are all zero.
- R2: A write of a PLL code that differs from `cfg_o` updates `cfg_o` on the next cycle, clears `lock_o` and sets the PLL request (`sub_q_o[0]`). A code is a PLL code when it is neither `001` nor `011`.
- R3: While the configuration is a stable PLL code and the oscillator is present, `lock_o` rises on the clock edge that samples the `lock_cycles`-th `ref_pulse` after the restart. Cycles without `ref_pulse` do not count, and a `lock_cycles` of 0 is treated as 1.
- R4: A write of another different PLL code, made either mid-count or after lock, clears `lock_o` and restarts the full count.
- R5: A write of the code already in effect leaves `cfg_o`, `lock_o`, the lock count and the PLL request unchanged.
- R6: In the codes `001` and `011`, `lock_o` stays 0 no matter how many reference pulses arrive, and entering either code raises no PLL request.
- R7: A rising `osc_missing`, including one that is already high when reset is released, sets the PLL request on the next cycle. While `osc_missing` is high, `lock_o` stays 0. After `osc_missing` falls, the lock count starts again from zero.
- R8: `src_base_o` follows `osc_missing`. `div2_o` is 1 exactly in code `011`. `pll_on_o` is 1 exactly when the code is a PLL code and the oscillator is present.
- R9: A subnode write replaces every request and enable bit. In `sub_wdata`, bit 2k is the request and bit 2k+1 is the enable of source k, and source 0 is the PLL. A hardware set in the same cycle wins over a written 0.
- R10: `node_irq_o` is 1 exactly when some source has both its request and its enable set.
- R11: `ext_set[k]` sets the request of source k+1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Configuration value to write |
| lock_cycles | input | CNT_W | Reference pulses needed to reach lock |
| ref_pulse | input | 1 | Reference cycle pulse seen by the lock model |
| osc_missing | input | 1 | Oscillator watchdog reports no input clock |
| ext_set | input | NSRC-1 | Request set pulses for the other node sources |
| sub_we | input | 1 | Subnode register write strobe |
| sub_wdata | input | 2*NSRC | Subnode write data, {enable,request} per source |
| sub_q_o | output | 2*NSRC | Subnode register contents, same layout |
| cfg_o | output | 3 | Configuration in effect |
| lock_o | output | 1 | PLL lock status |
| pll_req_o | output | 1 | PLL interrupt request |
| node_irq_o | output | 1 | Shared interrupt node output |
| pll_on_o | output | 1 | PLL drives the system clock |
| src_base_o | output | 1 | PLL base frequency replaces the oscillator |
| div2_o | output | 1 | Selected source is halved (prescaler) |

## Verification
The bench counts the edges up to lock exactly, so a lock that comes one pulse early or late is caught. It also checks that a zero limit still needs one pulse. It writes the same code mid-count and after lock. A design that treated such a write as a change would drop the lock or raise a spurious request. A design that ignored a real change mid-count would lock too early.

The bench holds pulses through non-PLL modes and through a missing oscillator, which catches a lock flag that leaks out in those states. It releases reset with the oscillator already missing, which catches an edge detector that misses that case. It also clears a request in the same cycle as a hardware set, which catches a design where software wins. A disabled source that still reaches the node is reported as well.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  localparam int unsigned CFG_W = 3;
  localparam logic [CFG_W-1:0] CFG_DIRECT = 3'b001;
  localparam logic [CFG_W-1:0] CFG_PRESC  = 3'b011;

  function automatic logic is_pll_code(input logic [CFG_W-1:0] c);
    return (c != CFG_DIRECT) && (c != CFG_PRESC);
  endfunction
endpackage

// File: rtl/pcl_cfg_reg.sv
module pcl_cfg_reg
  import pcl_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = CFG_DIRECT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic             mode_change,
  output logic             pll_restart
);
  // A write counts only when it alters the value in effect.
  assign mode_change = we && (wdata != cfg_q);
  assign pll_restart = mode_change && is_pll_code(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cfg_q <= RESET_CFG;
    else if (mode_change) cfg_q <= wdata;
  end
endmodule

// File: rtl/pcl_lock_model.sv
module pcl_lock_model #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             pll_mode,
  input  logic             hold,
  input  logic             ref_pulse,
  input  logic [CNT_W-1:0] lock_cycles,
  output logic             lock
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_nx;
  logic [EXT_W-1:0] target;

  assign cnt_nx = {1'b0, cnt_q} + EXT_W'(1);
  assign target = (lock_cycles == '0) ? EXT_W'(1) : {1'b0, lock_cycles};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lock  <= 1'b0;
    end else if (restart || !pll_mode || hold) begin
      cnt_q <= '0;
      lock  <= 1'b0;
    end else if (!lock && ref_pulse) begin
      if (cnt_nx >= target) lock  <= 1'b1;
      else                  cnt_q <= cnt_nx[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/pcl_irq_subnode.sv
module pcl_irq_subnode #(
  parameter int unsigned NSRC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   hw_set,
  input  logic              we,
  input  logic [2*NSRC-1:0] wdata,
  output logic [2*NSRC-1:0] regs,
  output logic              irq
);
  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] ena_q;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[k] <= 1'b0;
        ena_q[k] <= 1'b0;
      end else begin
        if (hw_set[k]) req_q[k] <= 1'b1;
        else if (we)   req_q[k] <= wdata[2*k];
        if (we)        ena_q[k] <= wdata[2*k+1];
      end
    end
    assign regs[2*k]   = req_q[k];
    assign regs[2*k+1] = ena_q[k];
  end

  assign irq = |(req_q & ena_q);
endmodule

// File: rtl/pcl_src_sel.sv
module pcl_src_sel
  import pcl_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  input  logic             osc_missing,
  output logic             pll_on,
  output logic             base_sel,
  output logic             div2
);
  always_comb begin
    base_sel = osc_missing;
    div2     = (cfg == CFG_PRESC);
    pll_on   = is_pll_code(cfg) && !osc_missing;
  end
endmodule

// File: rtl/pll_cfg_lock_ctrl.sv
module pll_cfg_lock_ctrl
  import pcl_pkg::*;
#(
  parameter int unsigned      NSRC      = 2,
  parameter int unsigned      CNT_W     = 8,
  parameter logic [CFG_W-1:0] RESET_CFG = CFG_DIRECT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [CNT_W-1:0]  lock_cycles,
  input  logic              ref_pulse,
  input  logic              osc_missing,
  input  logic [NSRC-2:0]   ext_set,
  input  logic              sub_we,
  input  logic [2*NSRC-1:0] sub_wdata,
  output logic [2*NSRC-1:0] sub_q_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              lock_o,
  output logic              pll_req_o,
  output logic              node_irq_o,
  output logic              pll_on_o,
  output logic              src_base_o,
  output logic              div2_o
);
  logic            mode_change;
  logic            pll_restart;
  logic            osc_prev_q;
  logic            osc_rise;
  logic [NSRC-1:0] hw_set;

  pcl_cfg_reg #(.RESET_CFG(RESET_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg_q(cfg_o), .mode_change(mode_change), .pll_restart(pll_restart)
  );

  pcl_lock_model #(.CNT_W(CNT_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .restart(mode_change),
    .pll_mode(is_pll_code(cfg_o)), .hold(osc_missing),
    .ref_pulse(ref_pulse), .lock_cycles(lock_cycles), .lock(lock_o)
  );

  // The previous value resets to 0, so an oscillator already missing at reset release shows up as a rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) osc_prev_q <= 1'b0;
    else        osc_prev_q <= osc_missing;
  end
  assign osc_rise = osc_missing && !osc_prev_q;

  assign hw_set = {ext_set, pll_restart || osc_rise};

  pcl_irq_subnode #(.NSRC(NSRC)) u_node (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .we(sub_we),
    .wdata(sub_wdata), .regs(sub_q_o), .irq(node_irq_o)
  );
  assign pll_req_o = sub_q_o[0];

  pcl_src_sel u_sel (
    .cfg(cfg_o), .osc_missing(osc_missing),
    .pll_on(pll_on_o), .base_sel(src_base_o), .div2(div2_o)
  );
endmodule

// File: rtl/pcl_checker.sv
module pcl_checker
  import pcl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic             ref_pulse,
  input logic             osc_missing,
  input logic             sub_we,
  input logic [CFG_W-1:0] cfg_o,
  input logic             lock_o,
  input logic             pll_req_o,
  input logic             pll_on_o,
  input logic             src_base_o
);
  AST_CHANGE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata != cfg_o && is_pll_code(cfg_wdata)) |=> (!lock_o && pll_req_o)); // R2

  AST_LOCK_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> ($past(ref_pulse) && !$past(osc_missing))); // R3

  AST_SAME_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata == cfg_o && !ref_pulse && !osc_missing && !sub_we)
      |=> ($stable(lock_o) && $stable(pll_req_o) && $stable(cfg_o))); // R5

  AST_NONPLL_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !is_pll_code(cfg_o) |-> !lock_o); // R6

  AST_OSC_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    osc_missing |=> !lock_o); // R7

  AST_OSC_SUBSTITUTE: assert property (@(posedge clk) disable iff (!rst_n)
    osc_missing |-> (src_base_o && !pll_on_o)); // R8
endmodule

bind pll_cfg_lock_ctrl pcl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .ref_pulse(ref_pulse), .osc_missing(osc_missing), .sub_we(sub_we),
  .cfg_o(cfg_o), .lock_o(lock_o), .pll_req_o(pll_req_o),
  .pll_on_o(pll_on_o), .src_base_o(src_base_o)
);

// File: tb/sim_pll_cfg_lock_ctrl.sv
module sim_pll_cfg_lock_ctrl;
  localparam int NSRC  = 2;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic [CNT_W-1:0] lock_cycles = 8'd4;
  logic ref_pulse = 1'b0;
  logic osc_missing = 1'b0;
  logic [NSRC-2:0] ext_set = '0;
  logic sub_we = 1'b0;
  logic [2*NSRC-1:0] sub_wdata = '0;
  logic [2*NSRC-1:0] sub_q_o;
  logic [2:0] cfg_o;
  logic lock_o, pll_req_o, node_irq_o, pll_on_o, src_base_o, div2_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pll_cfg_lock_ctrl #(.NSRC(NSRC), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .lock_cycles(lock_cycles), .ref_pulse(ref_pulse), .osc_missing(osc_missing),
    .ext_set(ext_set), .sub_we(sub_we), .sub_wdata(sub_wdata), .sub_q_o(sub_q_o),
    .cfg_o(cfg_o), .lock_o(lock_o), .pll_req_o(pll_req_o), .node_irq_o(node_irq_o),
    .pll_on_o(pll_on_o), .src_base_o(src_base_o), .div2_o(div2_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic wr_sub(input logic [2*NSRC-1:0] v);
    sub_we = 1'b1; sub_wdata = v;
    step();
    sub_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 cfg", cfg_o, 3'b001);
    chk("R1 lock", lock_o, 0);
    chk("R1 req", pll_req_o, 0);
    chk("R1 irq", node_irq_o, 0);
    chk("R1 sub", sub_q_o, 0);
  endtask

  task automatic t_pll_lock();
    ref_pulse = 1'b1;
    wr_cfg(3'b100);
    chk("R2 cfg", cfg_o, 3'b100);
    chk("R2 lock", lock_o, 0);
    chk("R2 req", pll_req_o, 1);
    step(3);
    chk("R3 lock early", lock_o, 0);
    step();
    chk("R3 lock at limit", lock_o, 1);
    chk("R8 pll_on", pll_on_o, 1);
    wr_sub('0);
    chk("R9 clear req", pll_req_o, 0);
    // R3: pulses absent do not count
    ref_pulse = 1'b0;
    wr_cfg(3'b010);
    wr_sub('0);
    step(6);
    chk("R3 no pulse", lock_o, 0);
    ref_pulse = 1'b1;
    step(3);
    chk("R3 resume early", lock_o, 0);
    step();
    chk("R3 resume lock", lock_o, 1);
    // R3: zero limit acts as one
    lock_cycles = 8'd0;
    wr_cfg(3'b111);
    chk("R3 zero restart", lock_o, 0);
    step();
    chk("R3 zero limit", lock_o, 1);
    lock_cycles = 8'd4;
    wr_sub('0);
  endtask

  task automatic t_same_and_restart();
    wr_cfg(3'b111);
    chk("R5 same lock", lock_o, 1);
    chk("R5 same req", pll_req_o, 0);
    chk("R5 same cfg", cfg_o, 3'b111);
    wr_cfg(3'b101);
    step(2);
    wr_cfg(3'b110);
    chk("R4 change req", pll_req_o, 1);
    step();
    wr_cfg(3'b110);
    chk("R5 same midcount", lock_o, 0);
    step();
    chk("R4 restart early", lock_o, 0);
    step();
    chk("R4 restart lock", lock_o, 1);
    wr_sub('0);
  endtask

  task automatic t_nonpll();
    wr_cfg(3'b011);
    chk("R6 presc lock", lock_o, 0);
    chk("R6 presc req", pll_req_o, 0);
    chk("R8 div2", div2_o, 1);
    chk("R8 pll_off", pll_on_o, 0);
    step(6);
    chk("R6 presc hold", lock_o, 0);
    wr_cfg(3'b001);
    step(6);
    chk("R6 direct lock", lock_o, 0);
    chk("R6 direct req", pll_req_o, 0);
    chk("R8 direct div2", div2_o, 0);
  endtask

  task automatic t_osc();
    wr_cfg(3'b100);
    step(4);
    wr_sub('0);
    chk("R3 relock", lock_o, 1);
    osc_missing = 1'b1;
    step();
    chk("R7 osc req", pll_req_o, 1);
    chk("R7 osc lock", lock_o, 0);
    chk("R8 base", src_base_o, 1);
    chk("R8 pll_on osc", pll_on_o, 0);
    step(6);
    chk("R7 osc hold", lock_o, 0);
    osc_missing = 1'b0;
    step(3);
    chk("R7 recount early", lock_o, 0);
    step();
    chk("R7 recount lock", lock_o, 1);
    osc_missing = 1'b1;
    wr_cfg(3'b011);
    chk("R8 presc base div2", {src_base_o, div2_o}, 2'b11);
    osc_missing = 1'b1;
    do_reset();
    step();
    chk("R7 osc at reset", pll_req_o, 1);
    chk("R7 osc at reset lock", lock_o, 0);
    osc_missing = 1'b0;
    step();
  endtask

  task automatic t_node();
    wr_sub(4'b0010);
    chk("R10 disabled pll", node_irq_o, 0);
    ext_set = 1'b1;
    step();
    ext_set = 1'b0;
    chk("R11 ext req", sub_q_o, 4'b0110);
    chk("R10 ext disabled", node_irq_o, 0);
    wr_sub(4'b1110);
    chk("R10 ext enabled", node_irq_o, 1);
    wr_sub(4'b1010);
    chk("R10 none pending", node_irq_o, 0);
    cfg_we = 1'b1; cfg_wdata = 3'b101;
    sub_we = 1'b1; sub_wdata = 4'b0010;
    step();
    cfg_we = 1'b0; sub_we = 1'b0;
    chk("R9 hw wins", sub_q_o, 4'b0011);
    chk("R10 pll pending", node_irq_o, 1);
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_reset();
    t_pll_lock();
    t_same_and_restart();
    t_nonpll();
    t_osc();
    t_node();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule